// File: doc/BRIEF.md
# Dual-Channel Converter Output Formatter

This block sits between the digital back end of a two-channel data converter and the output pads. On every sample it takes one raw conversion word per channel, each with an out-of-range flag. It encodes the words in a selectable number format and routes them onto two output buses. Each bus has data pins, a flag pin and a data clock pin. Every pin is paired with an output-enable, so the pad ring can float it.

The block runs on a word clock at twice the sample rate. An internal phase bit splits each sample period into a first half and a second half. The raw inputs are offset-binary codes. Routing has three modes. In dual-bus mode each channel drives its own bus. In interleaved mode both channels share one bus, one word per half period, and the channel order follows the chosen bus. In averaging mode the truncated mean of the two channels goes to the chosen bus. Bit order can be reversed per bus, and the pin state during power-down is programmable.

Top module: `adc_out_formatter`

## Requirements
- R1: While rst_n is low, every data, flag and clock output and every output-enable is 0.
- R2: A sample is captured at the first rising edge after reset release and at every second edge after that. Its first word is on the pins after the next edge and its second word after the edge after that. In dual-bus mode (mux_en=0, avg_en=0) channel A goes to bus A and channel B to bus B, and both words are equal.
- R3: fmt_sel selects the code as a function of the raw offset-binary input x. 2'b00 and 2'b11 give x unchanged. 2'b01 gives two's complement, which is x with its MSB inverted. 2'b10 gives Gray code, which is x XOR (x >> 1).
- R4: With mux_en=1, avg_en=0 and mux_bus_sel=0, bus A carries channel A in the first half and channel B in the second half. Bus B drives data 0 and flag 0.
- R5: With mux_en=1, avg_en=0 and mux_bus_sel=1, bus B carries channel B in the first half and channel A in the second half. Bus A drives data 0 and flag 0.
- R6: rev_a and rev_b reverse the pin order of bus A and bus B respectively. Reversal is applied after format conversion, so pin i carries code bit W-1-i.
- R7: With avg_en=1, the bus chosen by mux_bus_sel carries the code of floor((A+B)/2), formed from an 11-bit sum, in both halves. Its flag is the OR of both channel flags and the other bus is idle at zero. avg_en takes priority over mux_en.
- R8: With pwr_down=1, pd_state sets all data pins. 2'b00 and 2'b10 float them (value 0, enable 0), 2'b01 drives them low and 2'b11 drives them high. The flag and clock pins take the same state unless disabled.
- R9: oor_dis=1 floats both flag pins and dclk_dis=1 floats both clock pins, with value 0 and enable 0, in every mode including power-down.
- R10: The data clock on each bus is 0 while the first word of a sample is on the pins and 1 while the second word is, so it toggles once per word.
- R11: In dual-bus and interleaved modes each word carries the out-of-range flag of the channel it came from.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock, twice the sample rate |
| rst_n | input | 1 | Synchronous active-low reset |
| ch_a_data | input | 10 | Raw offset-binary word, channel A |
| ch_a_oor | input | 1 | Out-of-range flag, channel A |
| ch_b_data | input | 10 | Raw offset-binary word, channel B |
| ch_b_oor | input | 1 | Out-of-range flag, channel B |
| fmt_sel | input | 2 | Output number format |
| mux_en | input | 1 | Interleave both channels onto one bus |
| mux_bus_sel | input | 1 | Bus used in interleaved or averaging mode (0 = A, 1 = B) |
| avg_en | input | 1 | Averaging mode |
| rev_a | input | 1 | Reverse bus A pin order |
| rev_b | input | 1 | Reverse bus B pin order |
| pwr_down | input | 1 | Power-down request |
| pd_state | input | 2 | Pin state in power-down |
| oor_dis | input | 1 | Float both flag pins |
| dclk_dis | input | 1 | Float both clock pins |
| bus_a_d | output | 10 | Bus A data |
| bus_a_d_oe | output | 10 | Bus A data enables |
| bus_a_or | output | 1 | Bus A out-of-range flag |
| bus_a_or_oe | output | 1 | Bus A flag enable |
| bus_a_ck | output | 1 | Bus A data clock |
| bus_a_ck_oe | output | 1 | Bus A clock enable |
| bus_b_d | output | 10 | Bus B data |
| bus_b_d_oe | output | 10 | Bus B data enables |
| bus_b_or | output | 1 | Bus B out-of-range flag |
| bus_b_or_oe | output | 1 | Bus B flag enable |
| bus_b_ck | output | 1 | Bus B data clock |
| bus_b_ck_oe | output | 1 | Bus B clock enable |

## Verification
The hardest case to reach is a sample whose two interleaved words land in the correct half periods while the controls stay steady across both loads. A control change placed one cycle too early corrupts the second word of the previous sample. The stimulus therefore starts every sample on the even phase counted from reset release. It changes controls only after an idle pair of cycles, once the last second-word load has happened. This lets the scoreboard predict both words per sample, including averages at the code extremes (1023+1023, 1023+0, 1+0) and flag ORing.

// File: rtl/afmt_pkg.sv
// Package: shared encodings for the output formatter.
// Assumes: nothing; pure type definitions.
package afmt_pkg;
    typedef enum logic [1:0] {
        FMT_OFFSET     = 2'b00,
        FMT_TWOS       = 2'b01,
        FMT_GRAY       = 2'b10,
        FMT_OFFSET_ALT = 2'b11
    } fmt_e;

    typedef enum logic [1:0] {
        PD_FLOAT0 = 2'b00,
        PD_LOW    = 2'b01,
        PD_FLOAT1 = 2'b10,
        PD_HIGH   = 2'b11
    } pd_e;

    localparam int NUM_BUS = 2;
endpackage

// File: rtl/afmt_coder.sv
// Module: afmt_coder
// Converts a raw offset-binary word to the selected output number format.
// Assumes: the raw word is offset binary (all zeros = most negative).
module afmt_coder
    import afmt_pkg::*;
#(
    parameter int W = 10
) (
    input  logic [W-1:0] raw,
    input  logic [1:0]   fmt,
    output logic [W-1:0] coded
);
    logic [W-1:0] gray;

    // Gray code: each bit is the XOR of itself and its upper neighbour.
    for (genvar i = 0; i < W; i++) begin : g_gray
        if (i == W-1) begin : g_top
            assign gray[i] = raw[i];
        end else begin : g_low
            assign gray[i] = raw[i] ^ raw[i+1];
        end
    end

    // Format select.
    always_comb begin
        case (fmt_e'(fmt))
            FMT_TWOS: coded = {~raw[W-1], raw[W-2:0]};
            FMT_GRAY: coded = gray;
            default:  coded = raw;
        endcase
    end
endmodule

// File: rtl/afmt_bitrev.sv
// Module: afmt_bitrev
// Optionally mirrors the bit order of a word.
// Assumes: the enable is static for the word being passed.
module afmt_bitrev #(
    parameter int W = 10
) (
    input  logic [W-1:0] din,
    input  logic         en,
    output logic [W-1:0] dout
);
    logic [W-1:0] mirrored;

    // Mirror wiring.
    for (genvar i = 0; i < W; i++) begin : g_mir
        assign mirrored[i] = din[W-1-i];
    end

    // Select mirrored or straight order.
    assign dout = en ? mirrored : din;
endmodule

// File: rtl/afmt_avg.sv
// Module: afmt_avg
// Forms the truncated mean of two raw words and the combined range flag.
// Assumes: both words are unsigned offset-binary codes.
module afmt_avg #(
    parameter int W = 10
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         a_oor,
    input  logic         b_oor,
    output logic [W-1:0] mean,
    output logic         mean_oor
);
    localparam int SW = W + 1;
    logic [SW-1:0] sum;

    // Full-width sum, then drop the LSB.
    assign sum      = {1'b0, a} + {1'b0, b};
    assign mean     = W'(sum >> 1);
    assign mean_oor = a_oor | b_oor;
endmodule

// File: rtl/afmt_pin_drv.sv
// Module: afmt_pin_drv
// Registered pin stage of one bus: data, flag and clock with enables,
// applying the power-down pin state and the flag/clock driver disables.
// Assumes: pd_state encoding from afmt_pkg; disables override power-down.
module afmt_pin_drv
    import afmt_pkg::*;
#(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] word,
    input  logic         flag,
    input  logic         ck_nxt,
    input  logic         pd,
    input  logic [1:0]   pd_state,
    input  logic         oor_dis,
    input  logic         dclk_dis,
    output logic [W-1:0] d,
    output logic [W-1:0] d_oe,
    output logic         fl,
    output logic         fl_oe,
    output logic         ck,
    output logic         ck_oe
);
    logic pd_drive;
    logic pd_level;

    // Decode the power-down pin state.
    always_comb begin
        case (pd_e'(pd_state))
            PD_LOW:  begin pd_drive = 1'b1; pd_level = 1'b0; end
            PD_HIGH: begin pd_drive = 1'b1; pd_level = 1'b1; end
            default: begin pd_drive = 1'b0; pd_level = 1'b0; end
        endcase
    end

    // Output registers for every pin of the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d     <= '0;
            d_oe  <= '0;
            fl    <= 1'b0;
            fl_oe <= 1'b0;
            ck    <= 1'b0;
            ck_oe <= 1'b0;
        end else if (pd) begin
            d     <= {W{pd_level}};
            d_oe  <= {W{pd_drive}};
            fl    <= !oor_dis && pd_level;
            fl_oe <= !oor_dis && pd_drive;
            ck    <= !dclk_dis && pd_level;
            ck_oe <= !dclk_dis && pd_drive;
        end else begin
            d     <= word;
            d_oe  <= '1;
            fl    <= !oor_dis && flag;
            fl_oe <= !oor_dis;
            ck    <= !dclk_dis && ck_nxt;
            ck_oe <= !dclk_dis;
        end
    end
endmodule

// File: rtl/adc_out_formatter.sv
// Module: adc_out_formatter
// Captures one raw word per channel every sample period (two word-clock
// cycles), encodes it, routes it in dual, interleaved or averaging mode,
// mirrors per bus and drives two registered output buses.
// Assumes: clk runs at twice the sample rate; controls are held steady
// across both loads of a sample.
module adc_out_formatter
    import afmt_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] ch_a_data,
    input  logic              ch_a_oor,
    input  logic [DATA_W-1:0] ch_b_data,
    input  logic              ch_b_oor,
    input  logic [1:0]        fmt_sel,
    input  logic              mux_en,
    input  logic              mux_bus_sel,
    input  logic              avg_en,
    input  logic              rev_a,
    input  logic              rev_b,
    input  logic              pwr_down,
    input  logic [1:0]        pd_state,
    input  logic              oor_dis,
    input  logic              dclk_dis,
    output logic [DATA_W-1:0] bus_a_d,
    output logic [DATA_W-1:0] bus_a_d_oe,
    output logic              bus_a_or,
    output logic              bus_a_or_oe,
    output logic              bus_a_ck,
    output logic              bus_a_ck_oe,
    output logic [DATA_W-1:0] bus_b_d,
    output logic [DATA_W-1:0] bus_b_d_oe,
    output logic              bus_b_or,
    output logic              bus_b_or_oe,
    output logic              bus_b_ck,
    output logic              bus_b_ck_oe
);
    localparam int W      = DATA_W;
    localparam int NCODE  = 3;   // channel A, channel B, average
    localparam int IDX_A  = 0;
    localparam int IDX_B  = 1;
    localparam int IDX_M  = 2;

    logic         phase_q;       // 1: next load is first word
    logic [W-1:0] cap_a, cap_b;
    logic         cap_oa, cap_ob;
    logic [W-1:0] mean;
    logic         mean_oor;
    logic [W-1:0] raw_v   [NCODE];
    logic [W-1:0] code_v  [NCODE];
    logic [W-1:0] word_pre [NUM_BUS];
    logic         flag_pre [NUM_BUS];
    logic [W-1:0] word_out [NUM_BUS];
    logic         rev_v    [NUM_BUS];
    logic [W-1:0] d_v      [NUM_BUS];
    logic [W-1:0] doe_v    [NUM_BUS];
    logic         fl_v     [NUM_BUS];
    logic         floe_v   [NUM_BUS];
    logic         ck_v     [NUM_BUS];
    logic         ckoe_v   [NUM_BUS];

    // Half-period phase: toggles every word clock.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= 1'b0;
        else        phase_q <= ~phase_q;
    end

    // Sample capture at the start of each sample period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_a  <= '0;
            cap_b  <= '0;
            cap_oa <= 1'b0;
            cap_ob <= 1'b0;
        end else if (!phase_q) begin
            cap_a  <= ch_a_data;
            cap_b  <= ch_b_data;
            cap_oa <= ch_a_oor;
            cap_ob <= ch_b_oor;
        end
    end

    afmt_avg #(.W(W)) u_avg (
        .a        (cap_a),
        .b        (cap_b),
        .a_oor    (cap_oa),
        .b_oor    (cap_ob),
        .mean     (mean),
        .mean_oor (mean_oor)
    );

    assign raw_v[IDX_A] = cap_a;
    assign raw_v[IDX_B] = cap_b;
    assign raw_v[IDX_M] = mean;

    for (genvar c = 0; c < NCODE; c++) begin : g_code
        afmt_coder #(.W(W)) u_coder (
            .raw   (raw_v[c]),
            .fmt   (fmt_sel),
            .coded (code_v[c])
        );
    end

    // Route words to buses according to the mode.
    always_comb begin
        logic [W-1:0] stream_w;
        logic         stream_f;
        logic         prim_b;
        prim_b   = mux_bus_sel;
        stream_w = '0;
        stream_f = 1'b0;
        for (int i = 0; i < NUM_BUS; i++) begin
            word_pre[i] = '0;
            flag_pre[i] = 1'b0;
        end
        if (avg_en) begin
            stream_w = code_v[IDX_M];
            stream_f = mean_oor;
        end else if (phase_q ^ prim_b) begin
            stream_w = code_v[IDX_A];
            stream_f = cap_oa;
        end else begin
            stream_w = code_v[IDX_B];
            stream_f = cap_ob;
        end
        if (avg_en || mux_en) begin
            word_pre[prim_b] = stream_w;
            flag_pre[prim_b] = stream_f;
        end else begin
            word_pre[0] = code_v[IDX_A];
            flag_pre[0] = cap_oa;
            word_pre[1] = code_v[IDX_B];
            flag_pre[1] = cap_ob;
        end
    end

    assign rev_v[0] = rev_a;
    assign rev_v[1] = rev_b;

    for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
        afmt_bitrev #(.W(W)) u_rev (
            .din  (word_pre[b]),
            .en   (rev_v[b]),
            .dout (word_out[b])
        );

        afmt_pin_drv #(.W(W)) u_pins (
            .clk      (clk),
            .rst_n    (rst_n),
            .word     (word_out[b]),
            .flag     (flag_pre[b]),
            .ck_nxt   (~phase_q),
            .pd       (pwr_down),
            .pd_state (pd_state),
            .oor_dis  (oor_dis),
            .dclk_dis (dclk_dis),
            .d        (d_v[b]),
            .d_oe     (doe_v[b]),
            .fl       (fl_v[b]),
            .fl_oe    (floe_v[b]),
            .ck       (ck_v[b]),
            .ck_oe    (ckoe_v[b])
        );
    end

    assign bus_a_d     = d_v[0];
    assign bus_a_d_oe  = doe_v[0];
    assign bus_a_or    = fl_v[0];
    assign bus_a_or_oe = floe_v[0];
    assign bus_a_ck    = ck_v[0];
    assign bus_a_ck_oe = ckoe_v[0];
    assign bus_b_d     = d_v[1];
    assign bus_b_d_oe  = doe_v[1];
    assign bus_b_or    = fl_v[1];
    assign bus_b_or_oe = floe_v[1];
    assign bus_b_ck    = ck_v[1];
    assign bus_b_ck_oe = ckoe_v[1];
endmodule

// File: rtl/afmt_checker.sv
// Module: afmt_checker
// Temporal properties on the formatter pins, bound to the top module.
// Assumes: controls are sampled at the edge whose load they affect.
module afmt_checker #(
    parameter int W = 10
) (
    input logic         clk,
    input logic         rst_n,
    input logic         mux_en,
    input logic         mux_bus_sel,
    input logic         avg_en,
    input logic         pwr_down,
    input logic [1:0]   pd_state,
    input logic         oor_dis,
    input logic         dclk_dis,
    input logic [W-1:0] bus_a_d,
    input logic [W-1:0] bus_a_d_oe,
    input logic [W-1:0] bus_b_d,
    input logic [W-1:0] bus_b_d_oe,
    input logic         bus_a_or,
    input logic         bus_b_or,
    input logic         bus_a_or_oe,
    input logic         bus_b_or_oe,
    input logic         bus_a_ck,
    input logic         bus_a_ck_oe,
    input logic         bus_b_ck_oe
);
    AST_PD_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down && !pd_state[0] |=> bus_a_d_oe == '0 && bus_b_d_oe == '0); // R8
    AST_PD_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down && pd_state[0] |=>
            ($past(pd_state[1]) ? (bus_a_d == '1 && bus_b_d == '1)
                                : (bus_a_d == '0 && bus_b_d == '0))); // R8
    AST_FLAG_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        oor_dis |=> !bus_a_or_oe && !bus_b_or_oe); // R9
    AST_CLK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        dclk_dis |=> !bus_a_ck_oe && !bus_b_ck_oe); // R9
    AST_MUX_IDLE_B: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_down && !avg_en && mux_en && !mux_bus_sel |=> bus_b_d == '0 && !bus_b_or); // R4
    AST_MUX_IDLE_A: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_down && !avg_en && mux_en && mux_bus_sel |=> bus_a_d == '0 && !bus_a_or); // R5
    AST_AVG_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_down && avg_en |=>
            ($past(mux_bus_sel) ? bus_a_d == '0 : bus_b_d == '0)); // R7
    AST_CLK_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(!pwr_down && !dclk_dis) && !pwr_down && !dclk_dis
            |=> bus_a_ck != $past(bus_a_ck)); // R10
endmodule

bind adc_out_formatter afmt_checker #(.W(DATA_W)) u_chk (.*);

// File: tb/adc_out_formatter_bench.sv
// Scoreboard bench: the driver pushes two expected pin vectors per sample,
// the monitor pops and compares them on the cycle they are due.
module adc_out_formatter_bench;
    localparam int W = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0] ch_a_data = '0, ch_b_data = '0;
    logic ch_a_oor = 1'b0, ch_b_oor = 1'b0;
    logic [1:0] fmt_sel = 2'b00;
    logic mux_en = 1'b0, mux_bus_sel = 1'b0, avg_en = 1'b0;
    logic rev_a = 1'b0, rev_b = 1'b0, pwr_down = 1'b0;
    logic [1:0] pd_state = 2'b00;
    logic oor_dis = 1'b0, dclk_dis = 1'b0;
    logic [W-1:0] bus_a_d, bus_a_d_oe, bus_b_d, bus_b_d_oe;
    logic bus_a_or, bus_a_or_oe, bus_a_ck, bus_a_ck_oe;
    logic bus_b_or, bus_b_or_oe, bus_b_ck, bus_b_ck_oe;

    typedef struct {
        logic [47:0] v;
        int          due;
        string       tag;
    } item_t;
    item_t q[$];

    int cyc = 0;
    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    adc_out_formatter u_adc_out_formatter (.*);

    function automatic logic [W-1:0] code_of(logic [W-1:0] x);
        case (fmt_sel)
            2'b01:   return {~x[W-1], x[W-2:0]};
            2'b10:   return x ^ (x >> 1);
            default: return x;
        endcase
    endfunction

    function automatic logic [W-1:0] mirror(logic [W-1:0] x, logic en);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) r[i] = x[W-1-i];
        return en ? r : x;
    endfunction

    // One bus: {d, d_oe, or, or_oe, ck, ck_oe}.
    function automatic logic [23:0] bus_vec(logic [W-1:0] w, logic f, logic first, logic rv);
        logic drv, lvl;
        drv = pd_state[0];
        lvl = pd_state[0] & pd_state[1];
        if (pwr_down)
            return {{W{lvl}}, {W{drv}}, !oor_dis && lvl, !oor_dis && drv,
                    !dclk_dis && lvl, !dclk_dis && drv};
        return {mirror(w, rv), {W{1'b1}}, !oor_dis && f, !oor_dis,
                !dclk_dis && !first, !dclk_dis};
    endfunction

    function automatic logic [47:0] expect_vec(logic [W-1:0] a, logic [W-1:0] b,
                                               logic oa, logic ob, logic first);
        logic [W-1:0] wa, wb, sw;
        logic fa, fb, sf;
        logic [W:0] sum;
        wa = '0; wb = '0; fa = 1'b0; fb = 1'b0;
        sum = {1'b0, a} + {1'b0, b};
        if (avg_en) begin
            sw = code_of(sum[W:1]); sf = oa | ob;
        end else if (first ^ mux_bus_sel) begin
            sw = code_of(a); sf = oa;
        end else begin
            sw = code_of(b); sf = ob;
        end
        if (avg_en || mux_en) begin
            if (mux_bus_sel) begin wb = sw; fb = sf; end
            else             begin wa = sw; fa = sf; end
        end else begin
            wa = code_of(a); fa = oa; wb = code_of(b); fb = ob;
        end
        return {bus_vec(wa, fa, first, rev_a), bus_vec(wb, fb, first, rev_b)};
    endfunction

    function automatic logic [47:0] pins();
        return {bus_a_d, bus_a_d_oe, bus_a_or, bus_a_or_oe, bus_a_ck, bus_a_ck_oe,
                bus_b_d, bus_b_d_oe, bus_b_or, bus_b_or_oe, bus_b_ck, bus_b_ck_oe};
    endfunction

    task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic oa, input logic ob, input string tag);
        @(negedge clk);
        ch_a_data = a; ch_b_data = b; ch_a_oor = oa; ch_b_oor = ob;
        q.push_back('{v: expect_vec(a, b, oa, ob, 1'b1), due: cyc + 2, tag: tag});
        q.push_back('{v: expect_vec(a, b, oa, ob, 1'b0), due: cyc + 3, tag: tag});
        @(negedge clk);
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    // Monitor: compare every expected vector on its due cycle.
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0 && q[0].due == cyc) begin
                item_t it;
                it = q.pop_front();
                vectors++;
                if (pins() !== it.v) begin
                    miscompares++;
                    $display("FAIL %s: actual %h expected %h", it.tag, pins(), it.v);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        vectors++;
        if (pins() !== 48'h0) begin
            miscompares++;
            $display("FAIL R1 reset: actual %h expected %h", pins(), 48'h0);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R10 R11: dual-bus mode in all formats
        for (int f = 0; f < 4; f++) begin
            settle(); fmt_sel = 2'(f);
            drive(10'h000, 10'h3FF, 1'b0, 1'b1, "R2 R3 R10 R11 dual");
            drive(10'h200, 10'h1FF, 1'b1, 1'b0, "R2 R3 dual mid");
            drive(10'h2A5, 10'h05A, 1'b0, 1'b0, "R3 dual pattern");
        end

        // R6: per-bus reversal after format
        settle(); fmt_sel = 2'b01; rev_a = 1'b1;
        drive(10'h001, 10'h001, 1'b0, 1'b0, "R6 rev bus A");
        settle(); rev_a = 1'b0; rev_b = 1'b1; fmt_sel = 2'b10;
        drive(10'h0F3, 10'h30C, 1'b0, 1'b0, "R6 rev bus B gray");

        // R4: interleaved on bus A
        settle(); rev_b = 1'b0; fmt_sel = 2'b00; mux_en = 1'b1; mux_bus_sel = 1'b0;
        drive(10'h111, 10'h222, 1'b1, 1'b0, "R4 R11 mux bus A");
        drive(10'h3FE, 10'h001, 1'b0, 1'b1, "R4 R10 mux bus A");
        settle(); rev_a = 1'b1;
        drive(10'h123, 10'h321, 1'b0, 1'b0, "R4 R6 mux rev");

        // R5: interleaved on bus B
        settle(); rev_a = 1'b0; mux_bus_sel = 1'b1; fmt_sel = 2'b01;
        drive(10'h111, 10'h222, 1'b0, 1'b1, "R5 R11 mux bus B");
        drive(10'h000, 10'h3FF, 1'b1, 1'b0, "R5 mux bus B edges");

        // R7: averaging
        settle(); mux_en = 1'b0; avg_en = 1'b1; mux_bus_sel = 1'b0; fmt_sel = 2'b00;
        drive(10'h3FF, 10'h3FF, 1'b0, 1'b0, "R7 avg max");
        drive(10'h3FF, 10'h000, 1'b0, 1'b1, "R7 avg half oor");
        drive(10'h001, 10'h000, 1'b1, 1'b0, "R7 avg trunc");
        settle(); mux_bus_sel = 1'b1; mux_en = 1'b1; fmt_sel = 2'b10;
        drive(10'h155, 10'h2AA, 1'b0, 1'b0, "R7 avg bus B priority");

        // R8: power-down pin states
        settle(); avg_en = 1'b0; mux_en = 1'b0; mux_bus_sel = 1'b0;
        for (int p = 0; p < 4; p++) begin
            settle(); pwr_down = 1'b1; pd_state = 2'(p);
            drive(10'h2C3, 10'h13C, 1'b1, 1'b1, "R8 power-down state");
        end

        // R9: flag and clock driver disables
        settle(); pwr_down = 1'b0; oor_dis = 1'b1;
        drive(10'h3C0, 10'h00F, 1'b1, 1'b1, "R9 flag disable");
        settle(); oor_dis = 1'b0; dclk_dis = 1'b1;
        drive(10'h3C0, 10'h00F, 1'b1, 1'b1, "R9 clock disable");
        settle(); pwr_down = 1'b1; pd_state = 2'b11; oor_dis = 1'b1;
        drive(10'h000, 10'h000, 1'b0, 1'b0, "R9 R8 disables in power-down");

        settle(); settle();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule